// File: doc/BRIEF.md
# Machine status and interrupt-control registers

This block holds the machine-level status word and the interrupt-control state of a processor hart. That state is the interrupt enables, interrupt delegation, exception delegation, the software-owned interrupt-pending bits and the two trap-vector bases. It sits behind a single-cycle CSR access port. A read returns the addressed register combinationally. A write takes effect at the next rising clock edge. Every write passes through a per-register legality mask, so illegal field values never reach the stored state.

Two supervisor registers are windows rather than storage: the supervisor status view and the supervisor interrupt-enable/pending views. They read and write the machine registers through masks. The interrupt views are also gated by the current delegation setting. Hardware interrupt sources drive the pending word directly. A per-bit claim input decides whether hardware or software owns a delegable pending bit. All stored values are presented on dedicated output ports to the trap-entry logic.

Top module: `mscsr_top`

## Requirements
- R1: A machine status write changes only bits 1 (SIE), 3 (MIE), 5 (SPIE), 7 (MPIE), 8 (SPP), 12:11 (MPP), 14:13 (FS), 17 (MPRV), 18 (SUM), 19 (MXR), 20 (TVM), 21 (TW) and 22 (TSR), which together form mask 0x007E79AA. All other bits keep their value. Reset loads 0x00001800, which is MPP = 3, machine.
- R2: On every status write, bit 31 (summary dirty) is set when FS (bits 14:13) or XS (bits 16:15) equals 3, and is cleared otherwise.
- R3: The supervisor status view (address 0x100) reads the status word ANDed with 0x800DE133. This covers bits 0, 1, 4, 5, 8, 13–16, 18, 19 and 31. A write through it replaces only those bits, and the merged word then obeys R1 and R2.
- R4: Interrupt delegation (0x303) keeps only bits 1, 5 and 9 (mask 0x222). Interrupt enable (0x304) keeps only bits 1, 3, 5, 7, 9 and 11 (mask 0xAAA). Software interrupts sit at bits 1/3, timer at 5/7 and external at 9/11 for supervisor/machine. Both registers reset to zero.
- R5: The supervisor interrupt-enable view (0x104) reads enable AND delegation. A write through it alters only the enable bits that are currently delegated.
- R6: A write to a trap-vector base (machine 0x305, supervisor 0x105) whose bits 1:0 equal 2 or 3 leaves the register unchanged. Mode 0 and mode 1 values are stored whole. Both reset to zero.
- R7: The pending word (0x344) is the hardware input on machine bits and on claimed bits, and the software bit elsewhere. A machine pending write changes only software bits that are delegable (0x222) and unclaimed. A supervisor pending write (0x144) is further limited to the mask 0x103 and to the delegated bits. Supervisor pending reads are ANDed with delegation.
- R8: Exception delegation (0x302) keeps cause bits 0 to 13 and 15 (mask 0xBFFF). Bit 14 is never set.
- R9: With the access enable low, or at an address outside the ten decoded ones, no register changes. An undecoded address gives a hit flag of 0 and read data of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Access strobe |
| csr_we | input | 1 | Write when high, read when low |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Read value, combinational |
| csr_hit | output | 1 | Address decoded to a register of this block |
| hw_irq_pend | input | 32 | Hardware interrupt-pending levels |
| hw_irq_claim | input | 32 | Delegable pending bits owned by hardware |
| status_o | output | 32 | Machine status word |
| mie_o | output | 32 | Interrupt enables |
| mideleg_o | output | 32 | Interrupt delegation |
| medeleg_o | output | 32 | Exception delegation |
| pend_o | output | 32 | Effective pending word |
| mtvec_o | output | 32 | Machine trap-vector base |
| stvec_o | output | 32 | Supervisor trap-vector base |

## Verification
The hardest case is a supervisor pending write. It reaches the stored bit only when three independent conditions line up: the bit is delegated, it is not claimed by hardware, and it lies in the supervisor-writable set. The stimulus first fills the software pending bits through the machine view. It then clears them through the supervisor view with delegation set to the timer bit only, and again with full delegation. Comparing both results with the machine pending word shows which gate blocked the write. Claim ownership is tested in the same way by raising the claim on one bit, writing zero through the machine view, and dropping the claim again to expose the software bit underneath.

// File: rtl/mscsr_pkg.sv
package mscsr_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  // status field positions
  localparam int ST_UIE    = 0;
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_UPIE   = 4;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;
  localparam int ST_FS_LO  = 13;
  localparam int ST_XS_LO  = 15;
  localparam int ST_MPRV   = 17;
  localparam int ST_SUM    = 18;
  localparam int ST_MXR    = 19;
  localparam int ST_TVM    = 20;
  localparam int ST_TW     = 21;
  localparam int ST_TSR    = 22;
  localparam int ST_SD     = XLEN - 1;

  // interrupt bit positions
  localparam int IRQ_SW_U  = 0;
  localparam int IRQ_SW_S  = 1;
  localparam int IRQ_SW_M  = 3;
  localparam int IRQ_TMR_S = 5;
  localparam int IRQ_TMR_M = 7;
  localparam int IRQ_EXT_U = 8;
  localparam int IRQ_EXT_S = 9;
  localparam int IRQ_EXT_M = 11;

  localparam int EXC_CAUSES   = 16;
  localparam int EXC_RESERVED = 14;

  function automatic word_t bit_at(input int p);
    word_t w;
    w = '0;
    w[p] = 1'b1;
    return w;
  endfunction

  function automatic word_t two_bits_at(input int p);
    return bit_at(p) | bit_at(p + 1);
  endfunction

  function automatic word_t exc_mask_calc();
    word_t m;
    m = '0;
    for (int c = 0; c < EXC_CAUSES; c++) begin
      if (c != EXC_RESERVED) m[c] = 1'b1;
    end
    return m;
  endfunction

  localparam word_t SD_BIT = bit_at(ST_SD);

  localparam word_t M_WR_MASK =
      bit_at(ST_SIE) | bit_at(ST_MIE) | bit_at(ST_SPIE) | bit_at(ST_MPIE) |
      bit_at(ST_SPP) | two_bits_at(ST_MPP_LO) | two_bits_at(ST_FS_LO) |
      bit_at(ST_MPRV) | bit_at(ST_SUM) | bit_at(ST_MXR) | bit_at(ST_TVM) |
      bit_at(ST_TW) | bit_at(ST_TSR);

  localparam word_t S_VIEW_MASK =
      bit_at(ST_UIE) | bit_at(ST_SIE) | bit_at(ST_UPIE) | bit_at(ST_SPIE) |
      bit_at(ST_SPP) | two_bits_at(ST_FS_LO) | two_bits_at(ST_XS_LO) |
      bit_at(ST_SUM) | bit_at(ST_MXR) | SD_BIT;

  localparam word_t STATUS_RESET = two_bits_at(ST_MPP_LO);

  localparam word_t IRQ_S_MASK =
      bit_at(IRQ_SW_S) | bit_at(IRQ_TMR_S) | bit_at(IRQ_EXT_S);
  localparam word_t IRQ_ALL_MASK =
      IRQ_S_MASK | bit_at(IRQ_SW_M) | bit_at(IRQ_TMR_M) | bit_at(IRQ_EXT_M);
  localparam word_t SIP_SW_MASK =
      bit_at(IRQ_SW_S) | bit_at(IRQ_SW_U) | bit_at(IRQ_EXT_U);

  localparam word_t EXC_MASK = exc_mask_calc();

  // replace the bits of cur selected by win with those of val
  function automatic word_t window_merge(input word_t cur, input word_t val,
                                         input word_t win);
    return (cur & ~win) | (val & win);
  endfunction

  function automatic logic dirty_of(input word_t s);
    return (&s[ST_FS_LO +: 2]) | (&s[ST_XS_LO +: 2]);
  endfunction

  // machine-level status write rule: legal fields, then dirty summary
  function automatic word_t status_apply(input word_t cur, input word_t val);
    word_t nxt;
    nxt = window_merge(cur, val, M_WR_MASK);
    nxt[ST_SD] = dirty_of(nxt);
    return nxt;
  endfunction

  function automatic logic tvec_mode_legal(input word_t v);
    return v[1] == 1'b0;
  endfunction

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_MSTAT,
    SEL_SSTAT,
    SEL_MIE,
    SEL_SIE,
    SEL_MIDELEG,
    SEL_MEDELEG,
    SEL_MTVEC,
    SEL_STVEC,
    SEL_MIP,
    SEL_SIP
  } csr_sel_e;
endpackage

// File: rtl/mscsr_decode.sv
module mscsr_decode
  import mscsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] A_MSTAT   = 'h300,
  parameter logic [ADDR_W-1:0] A_SSTAT   = 'h100,
  parameter logic [ADDR_W-1:0] A_MIE     = 'h304,
  parameter logic [ADDR_W-1:0] A_SIE     = 'h104,
  parameter logic [ADDR_W-1:0] A_MIDELEG = 'h303,
  parameter logic [ADDR_W-1:0] A_MEDELEG = 'h302,
  parameter logic [ADDR_W-1:0] A_MTVEC   = 'h305,
  parameter logic [ADDR_W-1:0] A_STVEC   = 'h105,
  parameter logic [ADDR_W-1:0] A_MIP     = 'h344,
  parameter logic [ADDR_W-1:0] A_SIP     = 'h144
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (en) begin
      if      (addr == A_MSTAT)   sel = SEL_MSTAT;
      else if (addr == A_SSTAT)   sel = SEL_SSTAT;
      else if (addr == A_MIE)     sel = SEL_MIE;
      else if (addr == A_SIE)     sel = SEL_SIE;
      else if (addr == A_MIDELEG) sel = SEL_MIDELEG;
      else if (addr == A_MEDELEG) sel = SEL_MEDELEG;
      else if (addr == A_MTVEC)   sel = SEL_MTVEC;
      else if (addr == A_STVEC)   sel = SEL_STVEC;
      else if (addr == A_MIP)     sel = SEL_MIP;
      else if (addr == A_SIP)     sel = SEL_SIP;
    end
  end
endmodule

// File: rtl/mscsr_status.sv
module mscsr_status
  import mscsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_m,
  input  logic  wr_s,
  input  word_t wdata,
  output word_t status
);
  localparam word_t LOCKED = ~(M_WR_MASK | SD_BIT);
  localparam word_t S_OUTSIDE = ~(S_VIEW_MASK | SD_BIT);

  word_t status_q, status_d;
  word_t s_merged;   // supervisor write folded into the machine word

  always_comb begin
    s_merged = window_merge(status_q, wdata, S_VIEW_MASK);
    status_d = status_q;
    if (wr_m)      status_d = status_apply(status_q, wdata);
    else if (wr_s) status_d = status_apply(status_q, s_merged);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= STATUS_RESET;
    else        status_q <= status_d;
  end

  assign status = status_q;

  assert_locked_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status_q & LOCKED) == ($past(status_q) & LOCKED)));

  assert_dirty_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_SD] == ((status_q[ST_FS_LO] && status_q[ST_FS_LO+1]) ||
                        (status_q[ST_XS_LO] && status_q[ST_XS_LO+1])));

  assert_sview_confined_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && !wr_m) |=> ((status_q & S_OUTSIDE) == ($past(status_q) & S_OUTSIDE)));
endmodule

// File: rtl/mscsr_irq.sv
module mscsr_irq
  import mscsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_mie,
  input  logic  wr_sie,
  input  logic  wr_mideleg,
  input  logic  wr_medeleg,
  input  logic  wr_mip,
  input  logic  wr_sip,
  input  word_t wdata,
  input  word_t hw_pend,
  input  word_t hw_claim,
  output word_t mie,
  output word_t mideleg,
  output word_t medeleg,
  output word_t pend
);
  word_t mie_q, mie_d;
  word_t mideleg_q, mideleg_d;
  word_t medeleg_q, medeleg_d;
  word_t swp_q, swp_d;

  // named events for the checks below
  word_t hw_owned;     // bits whose pending level comes from hardware
  word_t sw_wmask_m;   // software-writable pending bits, machine view
  word_t sw_wmask_s;   // software-writable pending bits, supervisor view
  word_t sie_target;   // enable value requested through the supervisor view

  assign hw_owned   = ~IRQ_S_MASK | hw_claim;
  assign sw_wmask_m = IRQ_S_MASK & ~hw_claim;
  assign sw_wmask_s = sw_wmask_m & mideleg_q & SIP_SW_MASK;
  assign sie_target = window_merge(mie_q, wdata, mideleg_q);

  always_comb begin
    mie_d     = mie_q;
    mideleg_d = mideleg_q;
    medeleg_d = medeleg_q;
    swp_d     = swp_q;
    if (wr_mie)      mie_d = window_merge(mie_q, wdata, IRQ_ALL_MASK);
    else if (wr_sie) mie_d = window_merge(mie_q, sie_target, IRQ_ALL_MASK);
    if (wr_mideleg)  mideleg_d = window_merge(mideleg_q, wdata, IRQ_S_MASK);
    if (wr_medeleg)  medeleg_d = window_merge(medeleg_q, wdata, EXC_MASK);
    if (wr_mip)      swp_d = window_merge(swp_q, wdata, sw_wmask_m);
    else if (wr_sip) swp_d = window_merge(swp_q, wdata, sw_wmask_s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie_q     <= '0;
      mideleg_q <= '0;
      medeleg_q <= '0;
      swp_q     <= '0;
    end else begin
      mie_q     <= mie_d;
      mideleg_q <= mideleg_d;
      medeleg_q <= medeleg_d;
      swp_q     <= swp_d;
    end
  end

  assign mie     = mie_q;
  assign mideleg = mideleg_q;
  assign medeleg = medeleg_q;
  assign pend    = (hw_pend & hw_owned) | (swp_q & ~hw_owned);

  assert_deleg_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mideleg_q & ~IRQ_S_MASK) == '0);

  assert_sie_delegated_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sie && !wr_mie) |=> ((mie_q & ~$past(mideleg_q)) == ($past(mie_q) & ~$past(mideleg_q))));

  assert_claimed_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mip || wr_sip) |=> ((swp_q & $past(hw_owned)) == ($past(swp_q) & $past(hw_owned))));

  assert_exc_cause_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    medeleg_q[EXC_RESERVED] == 1'b0);
endmodule

// File: rtl/mscsr_tvec.sv
module mscsr_tvec
  import mscsr_pkg::*;
#(
  parameter word_t RESET_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  output word_t base
);
  word_t base_q;
  logic  accept;   // write with a legal mode field

  assign accept = wr && tvec_mode_legal(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= RESET_VAL;
    else if (accept) base_q <= wdata;
  end

  assign base = base_q;

  assert_reserved_mode_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[1]) |=> $stable(base_q));
endmodule

// File: rtl/mscsr_top.sv
module mscsr_top
  import mscsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] A_MSTAT   = 'h300,
  parameter logic [ADDR_W-1:0] A_SSTAT   = 'h100,
  parameter logic [ADDR_W-1:0] A_MIE     = 'h304,
  parameter logic [ADDR_W-1:0] A_SIE     = 'h104,
  parameter logic [ADDR_W-1:0] A_MIDELEG = 'h303,
  parameter logic [ADDR_W-1:0] A_MEDELEG = 'h302,
  parameter logic [ADDR_W-1:0] A_MTVEC   = 'h305,
  parameter logic [ADDR_W-1:0] A_STVEC   = 'h105,
  parameter logic [ADDR_W-1:0] A_MIP     = 'h344,
  parameter logic [ADDR_W-1:0] A_SIP     = 'h144,
  parameter logic [XLEN-1:0]   MTVEC_RST = '0,
  parameter logic [XLEN-1:0]   STVEC_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_hit,
  input  logic [XLEN-1:0]   hw_irq_pend,
  input  logic [XLEN-1:0]   hw_irq_claim,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   mie_o,
  output logic [XLEN-1:0]   mideleg_o,
  output logic [XLEN-1:0]   medeleg_o,
  output logic [XLEN-1:0]   pend_o,
  output logic [XLEN-1:0]   mtvec_o,
  output logic [XLEN-1:0]   stvec_o
);
  localparam int NUM_TVEC = 2;
  localparam word_t TVEC_RST [NUM_TVEC] = '{MTVEC_RST, STVEC_RST};

  csr_sel_e sel;
  logic     wr_go;
  word_t    status, mie, mideleg, medeleg, pend;
  word_t    tvec_base [NUM_TVEC];
  logic     tvec_wr   [NUM_TVEC];

  mscsr_decode #(
    .ADDR_W(ADDR_W), .A_MSTAT(A_MSTAT), .A_SSTAT(A_SSTAT), .A_MIE(A_MIE),
    .A_SIE(A_SIE), .A_MIDELEG(A_MIDELEG), .A_MEDELEG(A_MEDELEG),
    .A_MTVEC(A_MTVEC), .A_STVEC(A_STVEC), .A_MIP(A_MIP), .A_SIP(A_SIP)
  ) u_decode (
    .en  (csr_en),
    .addr(csr_addr),
    .sel (sel)
  );

  assign wr_go = csr_en && csr_we;

  mscsr_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_m  (wr_go && sel == SEL_MSTAT),
    .wr_s  (wr_go && sel == SEL_SSTAT),
    .wdata (csr_wdata),
    .status(status)
  );

  mscsr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mie    (wr_go && sel == SEL_MIE),
    .wr_sie    (wr_go && sel == SEL_SIE),
    .wr_mideleg(wr_go && sel == SEL_MIDELEG),
    .wr_medeleg(wr_go && sel == SEL_MEDELEG),
    .wr_mip    (wr_go && sel == SEL_MIP),
    .wr_sip    (wr_go && sel == SEL_SIP),
    .wdata     (csr_wdata),
    .hw_pend   (hw_irq_pend),
    .hw_claim  (hw_irq_claim),
    .mie       (mie),
    .mideleg   (mideleg),
    .medeleg   (medeleg),
    .pend      (pend)
  );

  assign tvec_wr[0] = wr_go && sel == SEL_MTVEC;
  assign tvec_wr[1] = wr_go && sel == SEL_STVEC;

  for (genvar g = 0; g < NUM_TVEC; g++) begin : g_tvec
    mscsr_tvec #(.RESET_VAL(TVEC_RST[g])) u_tvec (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (tvec_wr[g]),
      .wdata(csr_wdata),
      .base (tvec_base[g])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_MSTAT:   csr_rdata = status;
      SEL_SSTAT:   csr_rdata = status & S_VIEW_MASK;
      SEL_MIE:     csr_rdata = mie;
      SEL_SIE:     csr_rdata = mie & mideleg;
      SEL_MIDELEG: csr_rdata = mideleg;
      SEL_MEDELEG: csr_rdata = medeleg;
      SEL_MTVEC:   csr_rdata = tvec_base[0];
      SEL_STVEC:   csr_rdata = tvec_base[1];
      SEL_MIP:     csr_rdata = pend;
      SEL_SIP:     csr_rdata = pend & mideleg;
      default:     csr_rdata = '0;
    endcase
  end

  assign csr_hit   = sel != SEL_NONE;
  assign status_o  = status;
  assign mie_o     = mie;
  assign mideleg_o = mideleg;
  assign medeleg_o = medeleg;
  assign pend_o    = pend;
  assign mtvec_o   = tvec_base[0];
  assign stvec_o   = tvec_base[1];

  assert_idle_port_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_en) |=> ($stable(status_o) && $stable(mie_o) && $stable(mideleg_o) &&
                   $stable(medeleg_o) && $stable(mtvec_o) && $stable(stvec_o)));
endmodule

// File: tb/test_mscsr_top.sv
module test_mscsr_top;
  import mscsr_pkg::*;

  localparam time HALF = 2ns;   // 250 MHz

  localparam logic [11:0] AD_MST = 12'h300, AD_SST = 12'h100, AD_MIE = 12'h304,
                          AD_SIE = 12'h104, AD_MID = 12'h303, AD_MED = 12'h302,
                          AD_MTV = 12'h305, AD_STV = 12'h105, AD_MIP = 12'h344,
                          AD_SIP = 12'h144, AD_BAD = 12'h7C0;

  // masks restated from the requirements
  localparam word_t B_MWR  = 32'h007E_79AA;
  localparam word_t B_SV   = 32'h800D_E133;
  localparam word_t B_SDEL = 32'h0000_0222;
  localparam word_t B_IEN  = 32'h0000_0AAA;
  localparam word_t B_EXC  = 32'h0000_BFFF;
  localparam word_t B_SIPW = 32'h0000_0103;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_en = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  word_t csr_wdata = '0, csr_rdata;
  logic csr_hit;
  word_t hw_irq_pend = '0, hw_irq_claim = '0;
  word_t status_o, mie_o, mideleg_o, medeleg_o, pend_o, mtvec_o, stvec_o;

  always #HALF clk = ~clk;

  mscsr_top i_mscsr_top (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_hit(csr_hit), .hw_irq_pend(hw_irq_pend), .hw_irq_claim(hw_irq_claim),
    .status_o(status_o), .mie_o(mie_o), .mideleg_o(mideleg_o),
    .medeleg_o(medeleg_o), .pend_o(pend_o), .mtvec_o(mtvec_o), .stvec_o(stvec_o)
  );

  typedef struct {
    word_t exp;
    logic  exp_hit;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic mon_rd = 1'b0;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench reference model
  word_t m_st, m_ie, m_id, m_ed, m_sw, m_mt, m_stv;

  function automatic word_t ref_status(input word_t cur, input word_t v);
    word_t n;
    n = (cur & ~B_MWR) | (v & B_MWR);
    n[31] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    return n;
  endfunction

  function automatic word_t ref_pend();
    word_t hw_side;
    hw_side = ~B_SDEL | hw_irq_claim;
    return (hw_irq_pend & hw_side) | (m_sw & ~hw_side);
  endfunction

  task automatic check(input word_t act, input word_t exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read results against the scoreboard
  always @(posedge clk) begin
    #3ns;
    if (mon_rd) begin
      if (sb_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(csr_rdata, it.exp, it.tag);
        check({31'b0, csr_hit}, {31'b0, it.exp_hit}, {it.tag, " hit"});
      end
    end
  end

  task automatic wr(input logic [11:0] a, input word_t d);
    @(posedge clk); #1ns;
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d; mon_rd = 1'b0;
    @(posedge clk); #1ns;
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input word_t exp, input string tag,
                    input logic hit = 1'b1);
    sb_item_t it;
    @(posedge clk); #1ns;
    it.exp = exp; it.exp_hit = hit; it.tag = tag;
    sb_q.push_back(it);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a; mon_rd = 1'b1;
    @(posedge clk); #1ns;
    csr_en = 1'b0; mon_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_st = 32'h0000_1800; m_ie = '0; m_id = '0; m_ed = '0; m_sw = '0; m_mt = '0; m_stv = '0;
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;

    // reset state (R1, R4, R6)
    rd(AD_MST, m_st, "R1 reset status");
    rd(AD_MIE, '0, "R4 reset enables");
    rd(AD_MID, '0, "R4 reset deleg");
    rd(AD_MED, '0, "R8 reset exc deleg");
    rd(AD_MTV, '0, "R6 reset mtvec");
    rd(AD_MIP, '0, "R7 reset pending");
    @(posedge clk); #3ns;
    check(status_o, 32'h0000_1800, "R1 status port after reset");

    // R1 / R2: all-ones machine status write
    wr(AD_MST, '1); m_st = ref_status(m_st, '1);
    rd(AD_MST, m_st, "R1 status all ones");
    check(m_st, 32'h807E_79AA, "R2 model sanity");
    wr(AD_MST, 32'h0000_2000); m_st = ref_status(m_st, 32'h0000_2000);
    rd(AD_MST, 32'h0000_2000, "R2 FS=1 clears dirty");

    // R3: supervisor view
    wr(AD_SST, '1); m_st = ref_status(m_st, (m_st & ~B_SV) | B_SV);
    rd(AD_MST, 32'h800C_6122, "R3 sview write merged");
    rd(AD_SST, m_st & B_SV, "R3 sview read mask");
    wr(AD_MST, 32'h0000_0008); m_st = ref_status(m_st, 32'h0000_0008);
    wr(AD_SST, '0); m_st = ref_status(m_st, m_st & ~B_SV);
    rd(AD_MST, 32'h0000_0008, "R3 sview keeps MIE");

    // R4
    wr(AD_MID, '1); m_id = B_SDEL;
    rd(AD_MID, 32'h0000_0222, "R4 deleg mask");
    wr(AD_MIE, '1); m_ie = B_IEN;
    rd(AD_MIE, 32'h0000_0AAA, "R4 enable mask");

    // R5
    rd(AD_SIE, m_ie & m_id, "R5 sie read");
    wr(AD_SIE, '0); m_ie = (m_ie & ~m_id);
    rd(AD_MIE, 32'h0000_0888, "R5 sie write delegated");
    wr(AD_MID, '0); m_id = '0;
    rd(AD_SIE, '0, "R5 sie read undelegated");
    wr(AD_SIE, '1);
    rd(AD_MIE, m_ie, "R5 sie write no effect");

    // R8
    wr(AD_MED, '1); m_ed = B_EXC;
    rd(AD_MED, 32'h0000_BFFF, "R8 exc deleg mask");
    wr(AD_MED, 32'h0000_4000); m_ed = '0;
    rd(AD_MED, '0, "R8 reserved cause rejected");

    // R6
    wr(AD_MTV, 32'h0000_0100); m_mt = 32'h100;
    rd(AD_MTV, m_mt, "R6 direct mode stored");
    wr(AD_MTV, 32'h0000_0203);
    rd(AD_MTV, m_mt, "R6 mode 3 ignored");
    wr(AD_MTV, 32'h0000_0301); m_mt = 32'h301;
    rd(AD_MTV, m_mt, "R6 vectored stored");
    wr(AD_STV, 32'h0000_0402);
    rd(AD_STV, m_stv, "R6 stvec mode 2 ignored");
    wr(AD_STV, 32'h0000_0805); m_stv = 32'h805;
    rd(AD_STV, m_stv, "R6 stvec stored");
    @(posedge clk); #3ns;
    check(mtvec_o, 32'h0000_0301, "R6 mtvec port");

    // R7: machine pending writes and claims
    hw_irq_pend = 32'h0000_0800;
    wr(AD_MIP, '1); m_sw = B_SDEL;
    rd(AD_MIP, 32'h0000_0A22, "R7 sw pending set");
    hw_irq_claim = 32'h0000_0020;
    rd(AD_MIP, ref_pend(), "R7 claimed bit from hw");
    wr(AD_MIP, '0); m_sw = m_sw & ~(B_SDEL & ~hw_irq_claim);
    rd(AD_MIP, 32'h0000_0800, "R7 write under claim");
    hw_irq_claim = '0;
    rd(AD_MIP, 32'h0000_0820, "R7 claimed sw bit kept");

    // R7: supervisor pending view
    wr(AD_MIP, '1); m_sw = B_SDEL;
    wr(AD_MID, 32'h0000_0020); m_id = 32'h20;
    wr(AD_SIP, '0);
    rd(AD_MIP, 32'h0000_0A22, "R7 sip undelegated no effect");
    rd(AD_SIP, ref_pend() & m_id, "R7 sip read masked");
    wr(AD_MID, '1); m_id = B_SDEL;
    wr(AD_SIP, '0); m_sw = m_sw & ~(B_SIPW & m_id & B_SDEL);
    rd(AD_MIP, 32'h0000_0A20, "R7 sip clears only bit 1");
    rd(AD_SIP, 32'h0000_0220, "R7 sip read after write");

    // R9: idle strobe and undecoded address
    @(posedge clk); #1ns;
    csr_en = 1'b0; csr_we = 1'b1; csr_addr = AD_MST; csr_wdata = '0;
    @(posedge clk); #1ns;
    csr_we = 1'b0;
    @(posedge clk); #3ns;
    check(status_o, m_st, "R9 write without enable ignored");
    rd(AD_BAD, '0, "R9 undecoded read", 1'b0);
    wr(AD_BAD, '1);
    @(posedge clk); #3ns;
    check(status_o, m_st, "R9 undecoded write status");
    check(mie_o, m_ie, "R9 undecoded write enables");
    check(medeleg_o, m_ed, "R9 undecoded write exc deleg");
    check(stvec_o, m_stv, "R9 undecoded write stvec");

    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule